// File: doc/BRIEF.md
# Composite Video Summing Stage

This block takes a luma sample stream and a modulated chroma sample stream, both unsigned words of the same width, and turns them into three delay-matched outputs: the luma word, the chroma word and a composite word. The chroma input is offset binary: mid-code stands for zero, so the composite is the luma word plus the signed chroma excursion. The sum is clipped to the legal code range and then scaled down to fifteen sixteenths of full scale. This leaves headroom so that a composite converter of the same width as the luma and chroma converters is never driven past its range.

Samples are accepted on a valid strobe. Each pipeline stage loads only when the sample in front of it is valid, and the strobe travels beside the data. All three outputs and the output strobe therefore appear exactly two clock cycles after the input sample. Between valid samples the outputs hold their last value. The word width, the attenuation shift and the choice between rounding and truncation in the scaler are parameters.

Top module: `cvs_composite`

## Requirements
- R1: With rounding selected, `comp_out` equals s - floor((s + 2^(SHIFT-1)) / 2^SHIFT). Here s is the clipped sum from R2. With SHIFT = 4 this is round-to-nearest of s*15/16.
- R2: The pre-scaling sum is luma_in + chroma_in - 2^(DW-1). A negative result is forced to 0, and a result above 2^DW - 1 is forced to 2^DW - 1.
- R3: When `out_valid` is 1, `luma_out` equals the `luma_in` sampled with `in_valid` two clock cycles earlier.
- R4: When `out_valid` is 1, `chroma_out` equals the `chroma_in` sampled with `in_valid` two clock cycles earlier.
- R5: `out_valid` equals `in_valid` delayed by exactly two clock cycles.
- R6: A cycle with `out_valid` at 0 leaves all three data outputs unchanged. Input words presented while `in_valid` is 0 never reach the outputs.
- R7: While `rst_n` is 0 (synchronous, active low), all data outputs and `out_valid` read 0.
- R8: `comp_out` never exceeds the scaled value of full scale (959 for DW = 10 with rounding).
- R9: With truncation selected, `comp_out` equals s - floor(s / 2^SHIFT).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| luma_in | input | DW | Luma word, unsigned |
| chroma_in | input | DW | Chroma word, offset binary around mid-code |
| out_valid | output | 1 | Output sample strobe, two cycles after in_valid |
| luma_out | output | DW | Delay-matched luma |
| chroma_out | output | DW | Delay-matched chroma |
| comp_out | output | DW | Clipped and attenuated composite |

## Verification
The bench builds two 6-bit instances, one rounding and one truncating, both with SHIFT = 4. It sweeps every one of the 4096 luma/chroma pairs through them, which reaches every clipping edge and every rounding residue. A third instance at the default 10-bit width sees a widened copy of the same sweep, which includes the 0 and 1023 extremes and the 959 composite peak. Idle cycles carrying junk words are spread through the stream, so the hold behaviour and the strobe latency are exercised while real data is in flight.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

   typedef enum logic {
      SCALE_TRUNC = 1'b0,
      SCALE_ROUND = 1'b1
   } scale_mode_e;

   localparam int unsigned PIPE_DEPTH = 2;

endpackage

// File: rtl/cvs_gated_pipe.sv
module cvs_gated_pipe #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAGES-1:0] en,
   input  logic [W-1:0]      d,
   output logic [W-1:0]      q
);

   logic [W-1:0] stage_q [STAGES+1];

   assign stage_q[0] = d;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n)
               stage_q[i+1] <= '0;
            else if (en[i])
               stage_q[i+1] <= stage_q[i];
         end
      end
   endgenerate

   assign q = stage_q[STAGES];

endmodule

// File: rtl/cvs_sat_sum.sv
module cvs_sat_sum #(
   parameter int DW = 10
) (
   input  logic [DW-1:0] luma,
   input  logic [DW-1:0] chroma,
   output logic [DW-1:0] sum
);

   localparam int SW = DW + 2;
   localparam logic signed [SW-1:0] MID  = SW'(1 << (DW - 1));
   localparam logic signed [SW-1:0] TOPV = SW'((1 << DW) - 1);

   logic signed [SW-1:0] raw;

   always_comb begin
      raw = $signed({2'b00, luma}) + $signed({2'b00, chroma}) - MID;
      if (raw < 0)
         sum = '0;
      else if (raw > TOPV)
         sum = '1;
      else
         sum = raw[DW-1:0];
   end

endmodule

// File: rtl/cvs_atten.sv
module cvs_atten #(
   parameter int                  DW    = 10,
   parameter int                  SHIFT = 4,
   parameter cvs_pkg::scale_mode_e MODE  = cvs_pkg::SCALE_ROUND
) (
   input  logic [DW-1:0] x,
   output logic [DW-1:0] y
);

   localparam int unsigned HALF = 1 << (SHIFT - 1);

   logic [DW:0] part;

   generate
      if (MODE == cvs_pkg::SCALE_ROUND) begin : g_round
         always_comb part = ({1'b0, x} + (DW+1)'(HALF)) >> SHIFT;
      end else begin : g_trunc
         always_comb part = {1'b0, x} >> SHIFT;
      end
   endgenerate

   assign y = DW'({1'b0, x} - part);

endmodule

// File: rtl/cvs_composite.sv
module cvs_composite #(
   parameter int                  DW         = 10,
   parameter int                  SHIFT      = 4,
   parameter cvs_pkg::scale_mode_e SCALE_MODE = cvs_pkg::SCALE_ROUND
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] luma_in,
   input  logic [DW-1:0] chroma_in,
   output logic          out_valid,
   output logic [DW-1:0] luma_out,
   output logic [DW-1:0] chroma_out,
   output logic [DW-1:0] comp_out
);

   localparam int DEPTH = cvs_pkg::PIPE_DEPTH;
   localparam int PW    = 2 * DW;

   generate
      if (DW < 4 || DW > 16) begin : g_bad_dw
         $error("cvs_composite: DW must lie in 4..16");
      end
      if (SHIFT < 1 || SHIFT >= DW) begin : g_bad_shift
         $error("cvs_composite: SHIFT must lie in 1..DW-1");
      end
   endgenerate

   logic            v1_q;
   logic            v2_q;
   logic [DW-1:0]   sum_d;
   logic [DW-1:0]   sum_q;
   logic [DW-1:0]   scaled_d;
   logic [DW-1:0]   comp_q;
   logic [PW-1:0]   pass_q;
   logic [DEPTH-1:0] stage_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1_q <= 1'b0;
         v2_q <= 1'b0;
      end else begin
         v1_q <= in_valid;
         v2_q <= v1_q;
      end
   end

   assign stage_en = {v1_q, in_valid};

   cvs_sat_sum #(.DW(DW)) i_sum (
      .luma   (luma_in),
      .chroma (chroma_in),
      .sum    (sum_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         sum_q <= '0;
      else if (in_valid)
         sum_q <= sum_d;
   end

   cvs_atten #(.DW(DW), .SHIFT(SHIFT), .MODE(SCALE_MODE)) i_atten (
      .x (sum_q),
      .y (scaled_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         comp_q <= '0;
      else if (v1_q)
         comp_q <= scaled_d;
   end

   cvs_gated_pipe #(.W(PW), .STAGES(DEPTH)) i_pass (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (stage_en),
      .d     ({luma_in, chroma_in}),
      .q     (pass_q)
   );

   assign out_valid  = v2_q;
   assign comp_out   = comp_q;
   assign luma_out   = pass_q[PW-1:DW];
   assign chroma_out = pass_q[DW-1:0];

endmodule

// File: rtl/cvs_composite_chk.sv
module cvs_composite_chk #(
   parameter int                  DW         = 10,
   parameter int                  SHIFT      = 4,
   parameter cvs_pkg::scale_mode_e SCALE_MODE = cvs_pkg::SCALE_ROUND
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [DW-1:0] luma_in,
   input logic [DW-1:0] chroma_in,
   input logic          out_valid,
   input logic [DW-1:0] luma_out,
   input logic [DW-1:0] chroma_out,
   input logic [DW-1:0] comp_out,
   input logic          v1_q,
   input logic [DW-1:0] sum_q
);

   localparam int TOPV = (1 << DW) - 1;
   localparam int PEAK = (SCALE_MODE == cvs_pkg::SCALE_ROUND) ?
                         TOPV - ((TOPV + (1 << (SHIFT - 1))) >> SHIFT) :
                         TOPV - (TOPV >> SHIFT);

   function automatic logic [DW-1:0] clip_ref(input logic [DW-1:0] y, input logic [DW-1:0] c);
      int r;
      r = int'(y) + int'(c) - (1 << (DW - 1));
      if (r < 0) r = 0;
      if (r > TOPV) r = TOPV;
      return DW'(r);
   endfunction

   logic [1:0] since_rst;
   logic       armed;

   always_ff @(posedge clk) begin
      if (!rst_n)
         since_rst <= '0;
      else if (since_rst != 2'd3)
         since_rst <= since_rst + 2'd1;
   end

   assign armed = (since_rst >= 2'd2);

   // R5
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (out_valid == $past(in_valid, 2)));

   // R3
   luma_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && out_valid) |-> (luma_out == $past(luma_in, 2)));

   // R4
   chroma_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && out_valid) |-> (chroma_out == $past(chroma_in, 2)));

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !out_valid) |-> ($stable(comp_out) && $stable(luma_out) && $stable(chroma_out)));

   // R2
   clip_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && v1_q) |-> (sum_q == clip_ref($past(luma_in), $past(chroma_in))));

   // R8
   comp_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(comp_out) <= PEAK);

endmodule

bind cvs_composite cvs_composite_chk #(
   .DW(DW), .SHIFT(SHIFT), .SCALE_MODE(SCALE_MODE)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .luma_in    (luma_in),
   .chroma_in  (chroma_in),
   .out_valid  (out_valid),
   .luma_out   (luma_out),
   .chroma_out (chroma_out),
   .comp_out   (comp_out),
   .v1_q       (v1_q),
   .sum_q      (sum_q)
);

// File: tb/test_cvs_composite.sv
`timescale 1ns/1ps
module test_cvs_composite;

   localparam int SW = 6;
   localparam int FW = 10;
   localparam int SH = 4;
   localparam int NPAIRS = 1 << (2 * SW);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [SW-1:0] y_s = '0, c_s = '0;
   logic [FW-1:0] y_f = '0, c_f = '0;

   logic          ov_r, ov_t, ov_f;
   logic [SW-1:0] lo_r, co_r, cp_r, lo_t, co_t, cp_t;
   logic [FW-1:0] lo_f, co_f, cp_f;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   cvs_composite #(.DW(SW), .SHIFT(SH), .SCALE_MODE(cvs_pkg::SCALE_ROUND)) i_cvs_composite (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .luma_in(y_s), .chroma_in(c_s),
      .out_valid(ov_r), .luma_out(lo_r), .chroma_out(co_r), .comp_out(cp_r));

   cvs_composite #(.DW(SW), .SHIFT(SH), .SCALE_MODE(cvs_pkg::SCALE_TRUNC)) i_cvs_composite_trunc (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .luma_in(y_s), .chroma_in(c_s),
      .out_valid(ov_t), .luma_out(lo_t), .chroma_out(co_t), .comp_out(cp_t));

   cvs_composite #(.DW(FW), .SHIFT(SH), .SCALE_MODE(cvs_pkg::SCALE_ROUND)) i_cvs_composite_full (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .luma_in(y_f), .chroma_in(c_f),
      .out_valid(ov_f), .luma_out(lo_f), .chroma_out(co_f), .comp_out(cp_f));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int raw_sum(input int y, input int c, input int dw);
      return y + c - (1 << (dw - 1));
   endfunction

   function automatic int clip(input int r, input int dw);
      if (r < 0) return 0;
      if (r > (1 << dw) - 1) return (1 << dw) - 1;
      return r;
   endfunction

   function automatic int scale_rnd(input int s);
      return s - ((s + (1 << (SH - 1))) >> SH);
   endfunction

   function automatic int scale_trn(input int s);
      return s - (s >> SH);
   endfunction

   // two-deep model of what is in flight: index 1 reaches the outputs next
   bit p_v [2];
   int p_y [2], p_c [2], p_yf [2], p_cf [2];
   int h_y = 0, h_c = 0, h_cr = 0, h_ct = 0, h_yf = 0, h_cf = 0, h_cpf = 0;

   task automatic check_outputs();
      string tag;
      int r;
      if (p_v[1]) begin
         r = raw_sum(p_y[1], p_c[1], SW);
         h_y  = p_y[1];
         h_c  = p_c[1];
         h_cr = scale_rnd(clip(r, SW));
         h_ct = scale_trn(clip(r, SW));
         h_yf = p_yf[1];
         h_cf = p_cf[1];
         h_cpf = scale_rnd(clip(raw_sum(p_yf[1], p_cf[1], FW), FW));
         tag = ((r < 0) || (r > (1 << SW) - 1)) ? "R2" : "R1";
      end else begin
         tag = "R6";
      end
      // R5: strobe latency on all instances
      check("R5", int'(ov_r), int'(p_v[1]));
      check("R5", int'(ov_t), int'(p_v[1]));
      check("R5", int'(ov_f), int'(p_v[1]));
      // R3 / R4 pass-through (R6 when holding)
      check(p_v[1] ? "R3" : "R6", int'(lo_r), h_y);
      check(p_v[1] ? "R4" : "R6", int'(co_r), h_c);
      check(p_v[1] ? "R3" : "R6", int'(lo_f), h_yf);
      check(p_v[1] ? "R4" : "R6", int'(co_f), h_cf);
      // R1 / R2 rounding composite, R9 truncating composite
      check(tag, int'(cp_r), h_cr);
      check(p_v[1] ? "R9" : "R6", int'(cp_t), h_ct);
      check(p_v[1] ? "R1" : "R6", int'(cp_f), h_cpf);
      // R8 peak bound on the full-width instance
      check("R8", (int'(cp_f) <= 959) ? 1 : 0, 1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", checks, -1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stimulus
      int idx;
      int k;
      int drain;
      p_v[0] = 1'b0; p_v[1] = 1'b0;
      for (int i = 0; i < 2; i++) begin
         p_y[i] = 0; p_c[i] = 0; p_yf[i] = 0; p_cf[i] = 0;
      end

      // R7: reset state, with the strobe and data inputs busy
      repeat (2) @(negedge clk);
      in_valid = 1'b1; y_s = '1; c_s = '1; y_f = '1; c_f = '1;
      repeat (3) @(negedge clk);
      check("R7", int'(ov_r), 0);
      check("R7", int'(lo_r), 0);
      check("R7", int'(co_r), 0);
      check("R7", int'(cp_r), 0);
      check("R7", int'(ov_f), 0);
      check("R7", int'(cp_f), 0);
      check("R7", int'(cp_t), 0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      idx = 0;
      k = 0;
      drain = 0;
      while (drain < 4) begin
         check_outputs();
         p_v[1] = p_v[0]; p_y[1] = p_y[0]; p_c[1] = p_c[0];
         p_yf[1] = p_yf[0]; p_cf[1] = p_cf[0];
         if (idx < NPAIRS && (k % 7) != 3) begin
            y_s = SW'(idx >> SW);
            c_s = SW'(idx);
            y_f = {y_s, y_s[SW-1:SW-4]};
            c_f = {c_s, c_s[SW-1:SW-4]};
            in_valid = 1'b1;
            idx++;
         end else begin
            // junk words on idle cycles must not reach the outputs (R6)
            y_s = SW'(k * 37);
            c_s = SW'(k * 11 + 5);
            y_f = FW'(k * 151);
            c_f = FW'(k * 89 + 3);
            in_valid = 1'b0;
            if (idx >= NPAIRS) drain++;
         end
         p_v[0] = in_valid;
         p_y[0] = int'(y_s); p_c[0] = int'(c_s);
         p_yf[0] = int'(y_f); p_cf[0] = int'(c_f);
         k++;
         @(negedge clk);
      end
      check_outputs();

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule